// File: doc/BRIEF.md
# Flag-Setting Arithmetic Unit

The block is a combinational arithmetic unit wrapped around a small flag register. Each cycle it takes two operand words and a three-bit operation code and produces a result word. It also produces the next value of four condition flags: negative, zero, carry and overflow. The carry flag held in the register feeds the two carry-chaining operations. Two such operations can therefore be issued back to back to build wider sums and differences, one word at a time.

Subtraction follows a not-borrow convention. The carry flag is set when no borrow occurs, and the subtract-with-carry operation takes away the inverted held carry. A reverse subtract takes the first operand away from the second. The two saturating operations clamp to the most positive or most negative word instead of wrapping, and they never touch the flags. For every other operation the flags are updated only on cycles where the update control is high. The held flags appear in the top four bits of a status word, and all lower bits of that word are zero.

Top module: `arith_flag_unit`

## Requirements
- R1: Op code 0 gives a+b. Op code 1 gives a+b+C, where C is the held carry flag.
- R2: Op code 2 gives a-b. Op code 3 gives a-b-(1-C). For these, the carry flag is 1 exactly when no unsigned borrow occurs (so 5-6 clears it).
- R3: Op code 4 gives b-a, and its carry flag is 1 exactly when a <= b unsigned.
- R4: The next N flag equals the top bit of the result for op codes 0 to 4 and 7.
- R5: The next Z flag is 1 exactly when every result bit is zero, for op codes 0 to 4 and 7.
- R6: For op codes 0 and 1, the next C flag is the unsigned carry out of the top bit. For example, 0xFF000000+0xFF000000 sets it.
- R7: The next V flag is 1 exactly when the signed result does not fit in the word. For example, 0x7FFFFFFF+1 and 0x80000000-1 both set it.
- R8: The held flags load the next-flag value on a clock edge only when set_flags is high. Otherwise they keep their value. Op codes 5 and 6 never change them.
- R9: The status word carries N, Z, C, V in bits 31, 30, 29 and 28 of a 32-bit word, and all of its other bits are zero.
- R10: Op code 5 (saturating a+b) and op code 6 (saturating a-b) return the exact signed result when it fits. Otherwise they return 0x7FFFFFFF above the range and 0x80000000 below it.
- R11: Op code 7 behaves exactly like op code 0.
- R12: While rst_n is low, the held flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-carry, 4 reverse sub, 5 sat add, 6 sat sub, 7 add) |
| set_flags | input | 1 | Load next flags into the flag register this cycle |
| result | output | WIDTH | Arithmetic result |
| flags_next | output | 4 | Next N,Z,C,V value (bit 3 = N) |
| status | output | WIDTH | Held flags in the top nibble, zeros below |

## Verification
The bench builds the block with its default word width of 32. At that width the boundary words named in the requirements are real, reachable values: 0x7FFFFFFF, 0x80000000 and 0xFF000000. A 64-bit integer model in the bench computes carry and signed overflow from exact sums, so that the model does not reuse the inverted-operand adder. Directed chains pass the carry between add-carry and subtract-carry operations. A long random run then mixes all op codes, with set_flags toggled, against the same model.

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_next,
  output logic [WIDTH-1:0] status
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADC  = 3'd1;
  localparam logic [2:0] OP_SUB  = 3'd2;
  localparam logic [2:0] OP_SBC  = 3'd3;
  localparam logic [2:0] OP_RSB  = 3'd4;
  localparam logic [2:0] OP_QADD = 3'd5;
  localparam logic [2:0] OP_QSUB = 3'd6;
  localparam logic [WIDTH-1:0] SAT_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] SAT_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [3:0]       flags_q;
  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   usum, ssum;
  logic             sat_op, ovf, carry;
  logic [WIDTH-1:0] wrap;

  always_comb begin
    x   = op_a;
    y   = op_b;
    cin = 1'b0;
    unique case (op_sel)
      OP_ADC:  cin = flags_q[1];
      OP_SUB:  begin y = ~op_b; cin = 1'b1; end
      OP_SBC:  begin y = ~op_b; cin = flags_q[1]; end
      OP_RSB:  begin x = op_b; y = ~op_a; cin = 1'b1; end
      OP_QSUB: begin y = ~op_b; cin = 1'b1; end
      default: ;
    endcase
  end

  assign usum   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign ssum   = {x[MSB], x} + {y[MSB], y} + {{WIDTH{1'b0}}, cin};
  assign wrap   = usum[MSB:0];
  assign carry  = usum[WIDTH];
  assign ovf    = ssum[WIDTH] ^ ssum[MSB];
  assign sat_op = (op_sel == OP_QADD) || (op_sel == OP_QSUB);

  always_comb begin
    result = wrap;
    if (sat_op && ovf) result = ssum[WIDTH] ? SAT_MIN : SAT_MAX;
  end

  always_comb begin
    flags_next = flags_q;
    if (set_flags && !sat_op)
      flags_next = {wrap[MSB], (wrap == '0), carry, ovf};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 4'b0000;
    else        flags_q <= flags_next;
  end

  assign status = {flags_q, {(WIDTH-4){1'b0}}};

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(status));
  assert_sat_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_QADD || op_sel == OP_QSUB) |=> $stable(status));
  assert_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel != OP_QADD && op_sel != OP_QSUB) |-> flags_next[3] == result[MSB]);
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel != OP_QADD && op_sel != OP_QSUB) |-> flags_next[2] == (result == '0));
  assert_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[WIDTH-5:0] == '0);
  assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_QADD && !op_a[MSB] && !op_b[MSB]) |-> !result[MSB]);
endmodule

// File: tb/arith_flag_unit_tb.sv
module arith_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [2:0]  op_sel;
  logic        set_flags;
  logic [31:0] result;
  logic [3:0]  flags_next;
  logic [31:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] mflags;

  always #2 clk = ~clk;

  arith_flag_unit #(.WIDTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .result(result), .flags_next(flags_next), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic c, output logic [31:0] res, output logic [3:0] nf,
                                output logic sat);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint us, ss;
    logic   cf;
    sat = (op == 3'd5) || (op == 3'd6);
    case (op)
      3'd1:    begin us = ua + ub + c;  ss = sa + sb + c;  cf = us > 64'hFFFFFFFF; end
      3'd2:    begin us = ua - ub;      ss = sa - sb;      cf = ua >= ub; end
      3'd3:    begin us = ua - ub - (1 - c); ss = sa - sb - (1 - c); cf = ua >= ub + (1 - c); end
      3'd4:    begin us = ub - ua;      ss = sb - sa;      cf = ub >= ua; end
      3'd6:    begin us = ua - ub;      ss = sa - sb;      cf = 1'b0; end
      default: begin us = ua + ub;      ss = sa + sb;      cf = us > 64'hFFFFFFFF; end
    endcase
    res = us[31:0];
    if (sat) begin
      if (ss > 64'sd2147483647) res = 32'h7FFFFFFF;
      else if (ss < -64'sd2147483648) res = 32'h80000000;
      else res = ss[31:0];
    end
    nf = {res[31], res == 32'd0, cf, (ss > 64'sd2147483647) || (ss < -64'sd2147483648)};
  endfunction

  task automatic run(input string req, input logic [2:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic sf);
    logic [31:0] er;
    logic [3:0]  ef, nxt;
    logic        sat;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; set_flags = sf;
    #1;
    model(op, a, b, mflags[1], er, ef, sat);
    nxt = (sf && !sat) ? ef : mflags;
    check({req, " result"}, result, er);
    check({req, " flags_next"}, {28'd0, flags_next}, {28'd0, nxt});
    @(posedge clk);
    #1;
    mflags = nxt;
    check({req, " status"}, status, {mflags, 28'd0});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; op_sel = '0; set_flags = 1'b1;
    mflags = 4'b0000;
    repeat (3) @(posedge clk);
    #1 check("R12 reset", status, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    run("R6 carry", 3'd0, 32'hFF000000, 32'hFF000000, 1'b1);
    run("R1 adc carry in", 3'd1, 32'd5, 32'd16, 1'b1);
    run("R7 pos ovf", 3'd0, 32'h7FFFFFFF, 32'd1, 1'b1);
    run("R7 neg ovf", 3'd2, 32'h80000000, 32'd1, 1'b1);
    run("R2 borrow", 3'd2, 32'd5, 32'd6, 1'b1);
    run("R4 negative", 3'd2, 32'd5, 32'd6, 1'b1);
    run("R2 sbc borrow in", 3'd3, 32'd10, 32'd3, 1'b1);
    run("R5 zero", 3'd0, 32'd5, 32'hFFFFFFFB, 1'b1);
    run("R2 sbc no borrow", 3'd3, 32'd10, 32'd3, 1'b1);
    run("R3 rsb", 3'd4, 32'd7, 32'd3, 1'b1);
    run("R3 rsb eq", 3'd4, 32'd9, 32'd9, 1'b1);
    run("R8 hold", 3'd0, 32'h7FFFFFFF, 32'd1, 1'b0);
    run("R10 qadd high", 3'd5, 32'h7FFFFFF0, 32'h100, 1'b1);
    run("R10 qadd low", 3'd5, 32'h80000001, 32'h80000001, 1'b1);
    run("R10 qsub high", 3'd6, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1);
    run("R10 qsub low", 3'd6, 32'h80000000, 32'd1, 1'b1);
    run("R10 qsub exact", 3'd6, 32'd3, 32'd10, 1'b1);
    run("R11 op7", 3'd7, 32'hFFFFFFFF, 32'd1, 1'b1);
    run("R1 64bit lo", 3'd0, 32'hFFFFFFFF, 32'd2, 1'b1);
    run("R1 64bit hi", 3'd1, 32'd1, 32'd1, 1'b1);
    run("R9 status layout", 3'd0, 32'h80000000, 32'h80000000, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) ra = {ra[31], {31{ra[30]}}};
      run("R1 R2 R3 R8 R10 random", 3'($urandom_range(0, 7)), ra, rb, 1'($urandom));
    end

    @(negedge clk) rst_n = 1'b0;
    #1 check("R12 async reset", status, 32'd0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule